// File: doc/BRIEF.md
# Synchronous Receiver Hunt Detector

This block finds the character boundary in a synchronous serial receive stream. While it is hunting, every received bit enters a 16-bit window. The window is compared with the programmed sync pattern that the current mode selects. There are three sync modes:

- a single 8-bit sync character;
- a 16-bit double sync character built from two registers;
- a bit-oriented frame flag.

On the first match the block leaves hunt and gives a one-cycle boundary pulse. It then stays synchronized until something re-arms the hunt: the receiver is disabled, an abort is seen, or an enter-hunt command arrives. The hunt/sync status bit can raise a latched status interrupt on both of its edges. Software clears that interrupt with an acknowledge pulse.

The two pattern registers sit inside the block and are loaded through a shared write-data bus with one strobe each. The mode decides how each register is used. Character assembly, CRC checking and address matching are done by neighbouring logic, which uses `sync_pulse` as its start-of-character mark.

Top module: `sync_hunt_detector`

## Requirements
- R1: After reset, `hunt_stat`=1, `sync_pulse`=0 and `stat_irq`=0, and both pattern registers hold 00h, so an all-zero stream can match them.
- R2: In single mode (`rx_mode`=01), a valid bit that makes the 8 most recent bits equal the second register (earliest bit in the MSB) clears `hunt_stat` and raises `sync_pulse` for one cycle. Both take effect on the clock edge that samples that bit.
- R3: In double mode (`rx_mode`=10), the 16 most recent bits must equal {first register, second register}, with the first register received first. A match of the second register alone does nothing.
- R4: In flag mode (`rx_mode`=11), the 8 most recent bits are compared with the second register, which is programmed with 01111110. Only the first flag of a back-to-back run produces a pulse.
- R5: A match counts only once the pattern's full width of bits (8, or 16 in double mode) has arrived since hunt was last entered.
- R6: In any mode, `rx_enable`=0 or an `abort_det` pulse sets `hunt_stat` to 1 on the next edge and discards the collected bits.
- R7: An `enter_hunt` pulse in any sync mode sets `hunt_stat` to 1 and discards the collected bits.
- R8: In async mode (`rx_mode`=00), `enter_hunt` has no effect and no sync match ever occurs.
- R9: With `stat_ie`=1, each change of `hunt_stat` (in either direction) sets `stat_irq` on the same edge. `stat_irq` then holds until a `stat_ack` pulse. With `stat_ie`=0, `stat_irq` is never set.
- R10: Once synchronized, no further `sync_pulse` occurs until hunt is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wdata | input | 8 | Pattern register write data |
| cfg_wr_first | input | 1 | Write strobe, first pattern register |
| cfg_wr_second | input | 1 | Write strobe, second pattern register |
| rx_mode | input | 2 | 00 async, 01 single, 10 double, 11 flag |
| rx_enable | input | 1 | Receiver enable; low forces hunt |
| enter_hunt | input | 1 | One-cycle command to re-arm hunt |
| abort_det | input | 1 | Abort seen on the line; forces hunt |
| rx_valid | input | 1 | Strobe qualifying `rx_bit` |
| rx_bit | input | 1 | Received serial bit |
| stat_ie | input | 1 | Status interrupt enable |
| stat_ack | input | 1 | Pulse that clears `stat_irq` |
| hunt_stat | output | 1 | 1 while hunting, 0 when synchronized |
| sync_pulse | output | 1 | One-cycle character boundary mark |
| stat_irq | output | 1 | Latched status-change request |

## Verification
The vector table covers five stream shapes:

- a pattern placed after a few near-miss bits, which separates a true match from shifted lookalikes;
- a 16-bit pattern, and a stream that contains only its second half, which separates double from single comparison;
- back-to-back patterns and flags, which show that only the first produces a pulse;
- an async-mode stream that carries the pattern but must never synchronize.

All-zero streams sent straight after reset show that the registers reset to zero. They also show that the bit-count gate holds off a match until 8 or 16 bits have arrived. Directed sequences cover the following:

- an enter-hunt in the middle of a pattern, which must discard the partial bits;
- the interrupt on both edges, with its hold and acknowledge;
- the ignored command in async mode;
- re-arming by abort and by disable.

// File: rtl/sh_pkg.sv
package sh_pkg;
   typedef enum logic [1:0] {
      MODE_ASYNC = 2'b00,
      MODE_MONO  = 2'b01,
      MODE_DUAL  = 2'b10,
      MODE_FLAG  = 2'b11
   } hunt_mode_e;
endpackage

// File: rtl/sh_shift.sv
module sh_shift #(
   parameter int PAT_W = 16,
   localparam int CNT_W = $clog2(PAT_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic             din,
   output logic [PAT_W-1:0] win_nxt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAT_W);

   logic [PAT_W-1:0] win_q;
   logic [CNT_W-1:0] cnt_q;

   assign win_nxt = {win_q[PAT_W-2:0], din};
   assign cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         win_q <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         win_q <= win_nxt;
         cnt_q <= cnt_nxt;
      end
   end

   // R6
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
endmodule

// File: rtl/sh_match.sv
module sh_match
   import sh_pkg::*;
#(
   parameter int SYNC_W        = 8,
   parameter bit FLAG_FROM_REG = 1'b1,
   localparam int PAT_W = 2 * SYNC_W,
   localparam int CNT_W = $clog2(PAT_W + 1)
) (
   input  hunt_mode_e        mode,
   input  logic [PAT_W-1:0]  win,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [SYNC_W-1:0] pat_hi,
   input  logic [SYNC_W-1:0] pat_lo,
   output logic              hit
);
   localparam logic [CNT_W-1:0] NEED_ONE = CNT_W'(SYNC_W);
   localparam logic [CNT_W-1:0] NEED_TWO = CNT_W'(PAT_W);

   logic [SYNC_W-1:0] flag_pat;
   logic [SYNC_W-1:0] lo_pat;
   logic [SYNC_W-1:0] eq_lo;
   logic [SYNC_W-1:0] eq_hi;
   logic              lo_ok;
   logic              hi_ok;

   generate
      if (FLAG_FROM_REG) begin : g_flag_reg
         assign flag_pat = pat_lo;
      end else begin : g_flag_const
         assign flag_pat = SYNC_W'(8'h7E);
      end
   endgenerate

   assign lo_pat = (mode == MODE_FLAG) ? flag_pat : pat_lo;

   for (genvar i = 0; i < SYNC_W; i++) begin : g_eq
      assign eq_lo[i] = ~(win[i] ^ lo_pat[i]);
      assign eq_hi[i] = ~(win[i+SYNC_W] ^ pat_hi[i]);
   end

   assign lo_ok = &eq_lo;
   assign hi_ok = &eq_hi;

   always_comb begin
      unique case (mode)
         MODE_MONO,
         MODE_FLAG:  hit = lo_ok && (cnt >= NEED_ONE);
         MODE_DUAL:  hit = lo_ok && hi_ok && (cnt >= NEED_TWO);
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/sh_irq.sv
module sh_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ie,
   input  logic ack,
   input  logic hunt_now,
   input  logic hunt_next,
   output logic irq
);
   logic set_req;

   assign set_req = ie & (hunt_now ^ hunt_next);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= set_req | (irq & ~ack);
   end

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !ie) |=> !irq);
endmodule

// File: rtl/sync_hunt_detector.sv
module sync_hunt_detector
   import sh_pkg::*;
#(
   parameter int SYNC_W        = 8,
   parameter bit FLAG_FROM_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SYNC_W-1:0] cfg_wdata,
   input  logic              cfg_wr_first,
   input  logic              cfg_wr_second,
   input  logic [1:0]        rx_mode,
   input  logic              rx_enable,
   input  logic              enter_hunt,
   input  logic              abort_det,
   input  logic              rx_valid,
   input  logic              rx_bit,
   input  logic              stat_ie,
   input  logic              stat_ack,
   output logic              hunt_stat,
   output logic              sync_pulse,
   output logic              stat_irq
);
   localparam int PAT_W = 2 * SYNC_W;
   localparam int CNT_W = $clog2(PAT_W + 1);

   initial begin
      if (SYNC_W < 4)
         $fatal(1, "SYNC_W must be at least 4");
      if (!FLAG_FROM_REG && SYNC_W != 8)
         $fatal(1, "fixed flag pattern needs SYNC_W of 8");
   end

   hunt_mode_e        mode_e;
   logic [SYNC_W-1:0] first_q;
   logic [SYNC_W-1:0] second_q;
   logic              hunt_q;
   logic              hunt_d;
   logic              pulse_q;
   logic              rearm;
   logic              shift_en;
   logic              hit;
   logic              found;
   logic [PAT_W-1:0]  win_nxt;
   logic [CNT_W-1:0]  cnt_nxt;

   assign mode_e = hunt_mode_e'(rx_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= '0;
         second_q <= '0;
      end else begin
         if (cfg_wr_first)  first_q  <= cfg_wdata;
         if (cfg_wr_second) second_q <= cfg_wdata;
      end
   end

   assign rearm    = ~rx_enable | abort_det | (enter_hunt & (mode_e != MODE_ASYNC));
   assign shift_en = rx_valid & hunt_q & ~rearm;
   assign found    = shift_en & hit;

   sh_shift #(.PAT_W(PAT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rearm),
      .shift_en (shift_en),
      .din      (rx_bit),
      .win_nxt  (win_nxt),
      .cnt_nxt  (cnt_nxt)
   );

   sh_match #(.SYNC_W(SYNC_W), .FLAG_FROM_REG(FLAG_FROM_REG)) u_match (
      .mode   (mode_e),
      .win    (win_nxt),
      .cnt    (cnt_nxt),
      .pat_hi (first_q),
      .pat_lo (second_q),
      .hit    (hit)
   );

   always_comb begin
      hunt_d = hunt_q;
      if (rearm)      hunt_d = 1'b1;
      else if (found) hunt_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hunt_q  <= 1'b1;
         pulse_q <= 1'b0;
      end else begin
         hunt_q  <= hunt_d;
         pulse_q <= found;
      end
   end

   sh_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ie        (stat_ie),
      .ack       (stat_ack),
      .hunt_now  (hunt_q),
      .hunt_next (hunt_d),
      .irq       (stat_irq)
   );

   assign hunt_stat  = hunt_q;
   assign sync_pulse = pulse_q;

   // R2
   pulse_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> !hunt_q);

   // R10
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R6
   disable_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable || abort_det) |=> hunt_q);

   // R7
   cmd_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_hunt && mode_e != MODE_ASYNC) |=> hunt_q);

   // R8
   async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == MODE_ASYNC && rx_enable && !abort_det && !hunt_q) |=> !hunt_q);

   // R8
   async_nopulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == MODE_ASYNC) |=> !pulse_q);
endmodule

// File: tb/sim_sync_hunt_detector.sv
`timescale 1ns/1ps
module sim_sync_hunt_detector;
   typedef struct packed {
      logic [1:0]  mode;
      logic [7:0]  pa;
      logic [7:0]  pb;
      logic [23:0] stream;
      logic [4:0]  exp_at;
   } vec_t;

   localparam int NV = 7;
   localparam logic [4:0] NONE = 5'd31;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 8'h00, 8'hA5, 24'h3A5FFF, 5'd11},
      '{2'd2, 8'h96, 8'h3C, 24'hF963CF, 5'd19},
      '{2'd2, 8'h96, 8'h3C, 24'hFF3CFF, 5'd31},
      '{2'd3, 8'h00, 8'h7E, 24'hF07E00, 5'd15},
      '{2'd0, 8'h00, 8'hA5, 24'h3A5FFF, 5'd31},
      '{2'd1, 8'h00, 8'hA5, 24'hA5A5FF, 5'd7},
      '{2'd3, 8'h00, 8'h7E, 24'h7E7E7E, 5'd7}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       cfg_wr_first = 1'b0;
   logic       cfg_wr_second = 1'b0;
   logic [1:0] rx_mode = 2'd0;
   logic       rx_enable = 1'b0;
   logic       enter_hunt = 1'b0;
   logic       abort_det = 1'b0;
   logic       rx_valid = 1'b0;
   logic       rx_bit = 1'b0;
   logic       stat_ie = 1'b0;
   logic       stat_ack = 1'b0;
   logic       hunt_stat;
   logic       sync_pulse;
   logic       stat_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sync_hunt_detector u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata),
      .cfg_wr_first(cfg_wr_first), .cfg_wr_second(cfg_wr_second),
      .rx_mode(rx_mode), .rx_enable(rx_enable), .enter_hunt(enter_hunt),
      .abort_det(abort_det), .rx_valid(rx_valid), .rx_bit(rx_bit),
      .stat_ie(stat_ie), .stat_ack(stat_ack), .hunt_stat(hunt_stat),
      .sync_pulse(sync_pulse), .stat_irq(stat_irq)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_regs(input logic [7:0] a, input logic [7:0] b);
      @(negedge clk); cfg_wdata = a; cfg_wr_first = 1'b1;
      @(negedge clk); cfg_wr_first = 1'b0; cfg_wdata = b; cfg_wr_second = 1'b1;
      @(negedge clk); cfg_wr_second = 1'b0;
   endtask

   task automatic send(input logic b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int k = 7; k >= 0; k--) send(v[k]);
   endtask

   task automatic pulse_hunt();
      @(negedge clk); enter_hunt = 1'b1;
      @(negedge clk); enter_hunt = 1'b0;
   endtask

   task automatic pulse_abort();
      @(negedge clk); abort_det = 1'b1;
      @(negedge clk); abort_det = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); stat_ack = 1'b1;
      @(negedge clk); stat_ack = 1'b0;
   endtask

   task automatic rearm_by_disable();
      @(negedge clk); rx_enable = 1'b0;
      @(negedge clk); rx_enable = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(hunt_stat, 1'b1, "R1 hunt after reset");
      chk(sync_pulse, 1'b0, "R1 pulse after reset");
      chk(stat_irq, 1'b0, "R1 irq after reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(hunt_stat, 1'b1, "R1 hunt out of reset");

      // R1 and R5: zero registers, count gate in single mode
      rx_mode = 2'd1; rx_enable = 1'b1;
      for (int i = 0; i < 8; i++) begin
         send(1'b0);
         chk(sync_pulse, i == 7, "R5 single gate pulse");
         chk(hunt_stat, i < 7, "R1 second reg zero");
      end

      // R1 and R5: double mode needs 16 zeros
      rx_mode = 2'd2;
      rearm_by_disable();
      for (int i = 0; i < 16; i++) begin
         send(1'b0);
         chk(sync_pulse, i == 15, "R5 double gate pulse");
         chk(hunt_stat, i < 15, "R1 first reg zero");
      end

      // table walk
      for (int v = 0; v < NV; v++) begin
         string tag;
         case (VECS[v].mode)
            2'd0: tag = "R8";
            2'd1: tag = "R2";
            2'd2: tag = "R3";
            default: tag = "R4";
         endcase
         wr_regs(VECS[v].pa, VECS[v].pb);
         rx_mode = VECS[v].mode;
         rearm_by_disable();
         chk(hunt_stat, 1'b1, "R6 disable rearms");
         for (int i = 0; i < 24; i++) begin
            send(VECS[v].stream[23-i]);
            if (VECS[v].exp_at != NONE && i > int'(VECS[v].exp_at))
               chk(sync_pulse, 1'b0, "R10 no repeat pulse");
            else
               chk(sync_pulse, i == int'(VECS[v].exp_at), tag);
            chk(hunt_stat, (VECS[v].exp_at == NONE) || (i < int'(VECS[v].exp_at)), tag);
         end
      end

      // R7: enter_hunt mid-pattern discards partial bits
      wr_regs(8'h00, 8'hA5);
      rx_mode = 2'd1;
      rearm_by_disable();
      for (int k = 0; k < 4; k++) send(k[0] ? 1'b0 : 1'b1);
      pulse_hunt();
      for (int k = 0; k < 4; k++) begin
         send(k[0] ? 1'b1 : 1'b0);
         chk(hunt_stat, 1'b1, "R7 partial bits dropped");
      end
      send_byte(8'hA5);
      chk(sync_pulse, 1'b1, "R7 sync after rearm");
      chk(hunt_stat, 1'b0, "R7 synced");

      // R9: interrupt on rising edge, hold, ack
      stat_ie = 1'b1;
      pulse_hunt();
      chk(hunt_stat, 1'b1, "R7 command rearms");
      chk(stat_irq, 1'b1, "R9 irq on rise");
      @(negedge clk);
      chk(stat_irq, 1'b1, "R9 irq holds");
      pulse_ack();
      chk(stat_irq, 1'b0, "R9 irq acked");
      send_byte(8'hA5);
      chk(hunt_stat, 1'b0, "R2 synced again");
      chk(stat_irq, 1'b1, "R9 irq on fall");
      pulse_ack();
      chk(stat_irq, 1'b0, "R9 irq acked again");

      // R8: command ignored in async mode
      rx_mode = 2'd0;
      pulse_hunt();
      chk(hunt_stat, 1'b0, "R8 command ignored");
      chk(stat_irq, 1'b0, "R8 no irq from command");

      // R6: abort rearms
      pulse_abort();
      chk(hunt_stat, 1'b1, "R6 abort rearms");
      chk(stat_irq, 1'b1, "R9 irq on abort rise");
      pulse_ack();

      // R9: no irq when disabled
      stat_ie = 1'b0;
      rx_mode = 2'd1;
      send_byte(8'hA5);
      chk(hunt_stat, 1'b0, "R2 synced with ie off");
      chk(stat_irq, 1'b0, "R9 irq masked");

      // R6: disable rearms
      @(negedge clk); rx_enable = 1'b0;
      @(negedge clk);
      chk(hunt_stat, 1'b1, "R6 disable rearms");
      chk(stat_irq, 1'b0, "R9 masked on rise");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule